// File: doc/BRIEF.md
# Posted Interrupt Flag Register with Software Posting

This block keeps one posted-interrupt flag per peripheral source. A hardware source sets its flag on the rising edge of its request line. The CPU reads the flags through a register read port. It changes them through a write port that has two modes, chosen by a global software-interrupt enable input. With the enable low, a written zero clears the flag at that position. With the enable high, a written one posts an interrupt at that position. All other written values leave the flag as it was.

The flag vector goes out in parallel to a downstream interrupt controller, together with a combined pending signal. The register is wider than the number of sources. The upper bit positions are reserved: writes to them are dropped and they read as zero. The asynchronous active-low reset is synchronised inside the block before it is released, so the block comes out of reset two clock edges after the reset input rises.

Top module: `irq_post_reg`

## Requirements
- R1: After reset, all flags are 0, `irq_pending` is 0 and `rd_data` reads 0.
- R2: A 0-to-1 change on `hw_req[i]` sets flag i, and the flag is visible after the next rising clock edge. A request held high sets the flag only once, so a flag cleared while the request stays high remains clear.
- R3: A write with `sw_post_en`=0 clears every flag whose `wr_data` bit is 0. The result is the same whether or not that flag was set.
- R4: A write with `sw_post_en`=0 leaves every flag whose `wr_data` bit is 1 unchanged.
- R5: A write with `sw_post_en`=1 leaves every flag whose `wr_data` bit is 0 unchanged.
- R6: A write with `sw_post_en`=1 sets every flag whose `wr_data` bit is 1.
- R7: Flag i is returned on `rd_data[i]` for i below NUM_SRC. Bits NUM_SRC and above of `rd_data` always read 0, and writing ones into those positions has no effect.
- R8: When a hardware rising edge and a write that clears the same flag fall on the same cycle, the flag ends up set.
- R9: `irq_flags` equals the flag vector, and `irq_pending` is 1 exactly when at least one flag is set.
- R10: In a cycle that carries a write, `rd_data` shows the flags as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_SRC | Hardware interrupt request lines, edge sensitive |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | REG_W | Write data. Only bits below NUM_SRC are used |
| sw_post_en | input | 1 | Write mode: 0 means a zero clears, 1 means a one posts |
| rd_data | output | REG_W | Combinational register read value |
| irq_flags | output | NUM_SRC | Flag vector to the interrupt controller |
| irq_pending | output | 1 | High while any flag is set |

## Verification
Every write result and every hardware edge shows up on the outputs one clock edge after the cycle that carries it. The bench therefore drives a stimulus just after a rising edge and checks the outputs one nanosecond after the following edge. `rd_data` is combinational from the stored flags, so within the write cycle itself it must still hold the old value. The bench checks it before the edge for R10. The software paths are swept exhaustively over every starting flag value, every write value and both modes, with reserved bits set in the write data half of the time. The hardware edges are swept over all request patterns, including patterns that coincide with clearing writes.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
  localparam int unsigned NUM_SRC_DEF = 4;
  localparam int unsigned REG_W_DEF   = 8;

  typedef enum logic {
    WMODE_CLEAR = 1'b0,
    WMODE_POST  = 1'b1
  } wmode_e;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] rise
);
  logic [N-1:0] req_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[g] <= 1'b0;
      else        req_q[g] <= req[g];
    end
    assign rise[g] = req[g] & ~req_q[g];
  end

  // R2: a request held high yields a single set pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_post_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  logic         sw_en,
  output logic [N-1:0] flags
);
  wmode_e       mode;
  logic [N-1:0] after_wr;
  logic [N-1:0] flags_d;
  logic         upd;

  assign mode = sw_en ? WMODE_POST : WMODE_CLEAR;

  always_comb begin
    after_wr = flags;
    if (wr_en) begin
      case (mode)
        WMODE_POST:  after_wr = flags | wr_data;
        default:     after_wr = flags & wr_data;
      endcase
    end
    // hardware set has priority over a software clear
    flags_d = after_wr | rise;
    upd     = wr_en | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= flags_d;
  end

  // R2 / R8: a hardware edge always leaves its flag set
  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((flags & $past(rise)) == $past(rise)));
  // R3: clear mode drops flags written with 0 that had no edge
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_en) |=> ((flags & ~$past(wr_data) & ~$past(rise)) == '0));
  // R4: clear mode keeps flags written with 1
  a_r4_keep_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_en) |=> ((flags & $past(flags & wr_data)) == $past(flags & wr_data)));
  // R5: post mode never clears
  a_r5_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sw_en) |=> ((flags & $past(flags)) == $past(flags)));
  // R6: post mode sets flags written with 1
  a_r6_post: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sw_en) |=> ((flags & $past(wr_data)) == $past(wr_data)));
  // R2: without an edge or a write the flags hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (rise == '0)) |=> $stable(flags));
endmodule

// File: rtl/irq_post_reg.sv
module irq_post_reg
  import irq_post_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_SRC_DEF,
  parameter int unsigned REG_W   = REG_W_DEF   // must exceed NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               sw_post_en,
  output logic [REG_W-1:0]   rd_data,
  output logic [NUM_SRC-1:0] irq_flags,
  output logic               irq_pending
);
  logic [1:0]         rst_sync;
  logic               rst_n_i;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] flags;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  irq_rise_det #(.N(NUM_SRC)) u_rise (
    .clk   (clk),
    .rst_n (rst_n_i),
    .req   (hw_req),
    .rise  (rise)
  );

  irq_flag_bank #(.N(NUM_SRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .rise    (rise),
    .wr_en   (wr_en),
    .wr_data (wr_data[NUM_SRC-1:0]),
    .sw_en   (sw_post_en),
    .flags   (flags)
  );

  always_comb begin
    rd_data              = '0;
    rd_data[NUM_SRC-1:0] = flags;
  end

  assign irq_flags   = flags;
  assign irq_pending = |flags;

  // R7: reserved write bits leave the reserved read bits at zero
  a_r7_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && (wr_data[REG_W-1:NUM_SRC] != '0)) |=> (rd_data[REG_W-1:NUM_SRC] == '0));
  // R10: in a write cycle the read port still shows the stored value
  a_r10_old_read: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_en |-> (rd_data[NUM_SRC-1:0] == irq_flags));
endmodule

// File: tb/irq_post_reg_test.sv
module irq_post_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] hw_req;
  logic          wr_en;
  logic [RW-1:0] wr_data;
  logic          sw_post_en;
  logic [RW-1:0] rd_data;
  logic [NS-1:0] irq_flags;
  logic          irq_pending;

  int errors = 0;
  int checks = 0;
  logic [NS-1:0] exp_f;
  logic [NS-1:0] hw_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_post_reg #(.NUM_SRC(NS), .REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en),
    .wr_data(wr_data), .sw_post_en(sw_post_en), .rd_data(rd_data),
    .irq_flags(irq_flags), .irq_pending(irq_pending)
  );

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check({tag, " R7 rd_data"}, rd_data, {{(RW-NS){1'b0}}, exp_f});
    check({tag, " R9 irq_flags"}, {{(RW-NS){1'b0}}, irq_flags}, {{(RW-NS){1'b0}}, exp_f});
    check({tag, " R9 irq_pending"}, {{(RW-1){1'b0}}, irq_pending}, {{(RW-1){1'b0}}, (exp_f != '0)});
  endtask

  // one cycle: inputs applied just after an edge, results checked after the next
  task automatic step(input string tag, input logic [NS-1:0] hw, input logic we,
                      input logic [RW-1:0] wd, input logic sw);
    logic [NS-1:0] nxt;
    hw_req = hw; wr_en = we; wr_data = wd; sw_post_en = sw;
    #1;
    if (we) check({tag, " R10 read in write cycle"}, rd_data, {{(RW-NS){1'b0}}, exp_f});
    nxt = exp_f;
    if (we) nxt = sw ? (exp_f | wd[NS-1:0]) : (exp_f & wd[NS-1:0]);
    nxt = nxt | (hw & ~hw_prev);
    hw_prev = hw;
    @(posedge clk); #1;
    wr_en = 1'b0;
    exp_f = nxt;
    check_outs(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_req = '0; wr_en = 1'b0; wr_data = '0; sw_post_en = 1'b0;
    exp_f = '0; hw_prev = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_outs("R1 reset");

    // software paths: every start value, write value, mode
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 16; w++) begin
        for (int m = 0; m < 2; m++) begin
          logic [RW-1:0] wd;
          wd = {((w % 2) == 1) ? 4'hF : 4'h0, w[3:0]};
          step("R3 setup clear", '0, 1'b1, 8'h00, 1'b0);
          step("R6 setup post", '0, 1'b1, {4'h0, s[3:0]}, 1'b1);
          if (m == 0) step("R3/R4 clear-mode write", '0, 1'b1, wd, 1'b0);
          else        step("R5/R6 post-mode write", '0, 1'b1, wd, 1'b1);
        end
      end
    end

    // hardware edges, alone and against clearing writes
    for (int h = 0; h < 16; h++) begin
      step("R3 setup clear", '0, 1'b1, 8'h00, 1'b0);
      step("R2 rising edge", h[3:0], 1'b0, 8'h00, 1'b0);
      step("R2 held no reset", h[3:0], 1'b1, 8'h00, 1'b0);
      step("R2 held stays clear", h[3:0], 1'b0, 8'h00, 1'b0);
      step("R2 release", '0, 1'b0, 8'h00, 1'b0);
      step("R8 edge beats clear", h[3:0], 1'b1, 8'h00, 1'b0);
      step("R8 release", '0, 1'b0, 8'h00, 1'b0);
      step("R6 edge with post", h[3:0], 1'b1, {4'hF, ~h[3:0]}, 1'b1);
      step("R2 release", '0, 1'b0, 8'h00, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule